// File: doc/BRIEF.md
# Data Space Bank Switch Decoder

This block sits between the data-space bus of a small 8-bit controller and three 64-byte memory banks: a second RAM page and two EEPROM pages. Software picks a bank by writing a byte to a write-only select register at one fixed data-space address. Every later access in the low window (addresses 00h to 3Fh) is then steered to the selected bank. The block drives that bank's chip select and a 6-bit local offset, and returns its read data. Accesses outside the window pass through to the rest of the data map.

The select register holds one bit per bank and is deliberately left out of reset. It keeps its contents across reset and across any event other than an explicit byte write. A write that comes with the single-bit-operation strobe is dropped. While the EEPROM parallel-write mode is active, the EEPROM page bits are frozen. If software leaves more than one bank enabled, all of them respond in parallel and a clash flag reports the condition. The reset input is used only to qualify the block's built-in checks; the register never sees it.

Top module: `dspace_bank_steer`

## Requirements
- R1: A byte write (write strobe high, bit-operation strobe low) to address E8h latches the selection at the next clock edge. Data bit 0 enables EEPROM page 0, bit 1 enables EEPROM page 1 and bit 4 enables RAM page 2.
- R2: Data bits 2, 3, 5, 6 and 7 of a select write enable nothing. Writing ECh leaves every bank disabled.
- R3: A read of E8h returns FFh and asserts no chip select.
- R4: An access (read or write strobe) to 00h–3Fh asserts the chip select of each enabled bank, with bank_cs[0] for EEPROM page 0, bank_cs[1] for EEPROM page 1 and bank_cs[2] for RAM page 2. bank_offset carries address bits 5:0 and bank_we is high on a write.
- R5: With no bank enabled (select value 00h), a window read returns 00h and no chip select is asserted.
- R6: Asserting reset does not change the latched selection.
- R7: A write to E8h with the bit-operation strobe high leaves the selection unchanged.
- R8: While ee_par_wr_mode is high, a select write leaves both EEPROM page bits unchanged, while the RAM page 2 bit still updates.
- R9: When two or more banks are enabled, bank_clash is high for as long as they stay enabled. A window access asserts every enabled chip select, and the read data is the bitwise OR of the enabled banks' data.
- R10: An access outside 00h–3Fh other than E8h asserts no chip select and returns map_rdata.
- R11: A write to any address other than E8h leaves the selection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, qualifies checks only; the select register ignores it |
| cpu_addr | input | 8 | Data-space address |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_bitop | input | 1 | Marks the access as a single-bit set/clear |
| ee_par_wr_mode | input | 1 | EEPROM parallel-write mode active |
| map_rdata | input | 8 | Read data from the rest of the data map |
| bank_rdata | input | 24 | Bank read data, bank i in bits [8i+7:8i] |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| bank_cs | output | 3 | Per-bank chip selects |
| bank_offset | output | 6 | Offset inside the bank |
| bank_we | output | 1 | Write enable toward selected banks |
| bank_clash | output | 1 | More than one bank enabled |

## Verification
The bench builds the block with its defaults: an 8-bit address, a 6-bit window and the select register at E8h. With these values the window boundary at 3Fh/40h, the register address and the neighbouring address E9h can all be driven directly. The bank data values 11h, 22h and 44h are distinct single-nibble patterns, so any OR of enabled banks maps to a unique byte. Every one-hot selection, the empty selection, a three-way clash and a clash built up under parallel-write mode are reached.

// File: rtl/dbank_pkg.sv
package dbank_pkg;
  localparam int unsigned NBANK = 3;
  // bank index -> write-data bit that enables it
  localparam int unsigned SRC_BIT [NBANK] = '{0, 1, 4};
  // banks whose enable freezes during EEPROM parallel write
  localparam logic [NBANK-1:0] EE_MASK = 3'b011;
endpackage

// File: rtl/bank_sel_reg.sv
module bank_sel_reg
  import dbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'hE8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              bitop,
  input  logic              ee_par,
  output logic [NBANK-1:0]  sel
);
  logic             byte_hit;
  logic [NBANK-1:0] sel_en;
  logic [NBANK-1:0] sel_d;
  logic [NBANK-1:0] sel_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    byte_hit = wr && !bitop && (addr == SEL_ADDR);
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_bit
    always_comb begin
      sel_en[i] = byte_hit && !(EE_MASK[i] && ee_par);
      sel_d[i]  = wdata[SRC_BIT[i]];
    end
    // intentionally not reset: contents survive reset
    always_ff @(posedge clk) begin
      if (sel_en[i]) sel_q[i] <= sel_d[i];
    end
  end

  assign sel = sel_q;

  p_bitop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bitop) |=> $stable(sel_q));
  p_other_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != SEL_ADDR) |=> $stable(sel_q));
  p_parwr_ee_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ee_par |=> $stable(sel_q & EE_MASK));
endmodule

// File: rtl/bank_window_decode.sv
module bank_window_decode
  import dbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned WIN_BITS = 6,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'hE8
) (
  input  logic                ac_rd,
  input  logic                ac_wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NBANK-1:0]    sel,
  output logic                in_win,
  output logic                reg_hit,
  output logic [NBANK-1:0]    cs,
  output logic [WIN_BITS-1:0] offset,
  output logic                clash
);
  localparam int unsigned HI_W = ADDR_W - WIN_BITS;

  always_comb begin
    in_win  = (addr[ADDR_W-1:WIN_BITS] == {HI_W{1'b0}});
    reg_hit = (addr == SEL_ADDR);
    cs      = sel & {NBANK{in_win && (ac_rd || ac_wr)}};
    offset  = addr[WIN_BITS-1:0];
    clash   = ($countones(sel) > 1);
  end
endmodule

// File: rtl/bank_rdata_mux.sv
module bank_rdata_mux
  import dbank_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                    in_win,
  input  logic                    reg_hit,
  input  logic [NBANK-1:0]        sel,
  input  logic [NBANK*DATA_W-1:0] bank_rdata,
  input  logic [DATA_W-1:0]       map_rdata,
  output logic [DATA_W-1:0]       rdata
);
  logic [DATA_W-1:0] or_data;

  always_comb begin
    or_data = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (sel[i]) or_data = or_data | bank_rdata[i*DATA_W +: DATA_W];
    end
    if (in_win)       rdata = or_data;
    else if (reg_hit) rdata = '1;
    else              rdata = map_rdata;
  end
endmodule

// File: rtl/dspace_bank_steer.sv
module dspace_bank_steer
  import dbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WIN_BITS = 6,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'hE8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  input  logic                    cpu_rd,
  input  logic                    cpu_wr,
  input  logic                    cpu_bitop,
  input  logic                    ee_par_wr_mode,
  input  logic [DATA_W-1:0]       map_rdata,
  input  logic [NBANK*DATA_W-1:0] bank_rdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic [NBANK-1:0]        bank_cs,
  output logic [WIN_BITS-1:0]     bank_offset,
  output logic                    bank_we,
  output logic                    bank_clash
);
  logic [NBANK-1:0] sel;
  logic             in_win;
  logic             reg_hit;

  bank_sel_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_ADDR(SEL_ADDR)) u_sel (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .wdata(cpu_wdata),
    .wr(cpu_wr), .bitop(cpu_bitop), .ee_par(ee_par_wr_mode), .sel(sel)
  );

  bank_window_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .SEL_ADDR(SEL_ADDR)) u_dec (
    .ac_rd(cpu_rd), .ac_wr(cpu_wr), .addr(cpu_addr), .sel(sel),
    .in_win(in_win), .reg_hit(reg_hit), .cs(bank_cs),
    .offset(bank_offset), .clash(bank_clash)
  );

  bank_rdata_mux #(.DATA_W(DATA_W)) u_mux (
    .in_win(in_win), .reg_hit(reg_hit), .sel(sel),
    .bank_rdata(bank_rdata), .map_rdata(map_rdata), .rdata(cpu_rdata)
  );

  assign bank_we = cpu_wr && (|bank_cs);

  p_multi_cs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bank_cs) > 1) |-> bank_clash);
  p_reg_read_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == SEL_ADDR) |-> (cpu_rdata == '1 && bank_cs == '0));
  p_outside_no_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1:WIN_BITS] != '0) |-> (bank_cs == '0));
  p_offset_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_cs) |-> (bank_offset == cpu_addr[WIN_BITS-1:0]));
endmodule

// File: tb/dspace_bank_steer_bench.sv
module dspace_bank_steer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cpu_addr, cpu_wdata, map_rdata, cpu_rdata;
  logic       cpu_rd, cpu_wr, cpu_bitop, ee_par_wr_mode;
  logic [23:0] bank_rdata;
  logic [2:0] bank_cs;
  logic [5:0] bank_offset;
  logic       bank_we, bank_clash;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dspace_bank_steer u_dspace_bank_steer (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_bitop(cpu_bitop),
    .ee_par_wr_mode(ee_par_wr_mode), .map_rdata(map_rdata),
    .bank_rdata(bank_rdata), .cpu_rdata(cpu_rdata), .bank_cs(bank_cs),
    .bank_offset(bank_offset), .bank_we(bank_we), .bank_clash(bank_clash)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d, input logic bo);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_bitop = bo;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_bitop = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp_d,
                        input logic [2:0] exp_cs, input logic exp_clash);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    chk(tag, "rdata", int'(cpu_rdata), int'(exp_d));
    chk(tag, "cs", int'(bank_cs), int'(exp_cs));
    chk(tag, "clash", int'(bank_clash), int'(exp_clash));
    if (exp_cs != 3'b000) chk(tag, "offset", int'(bank_offset), int'(a[5:0]));
    cpu_rd = 1'b0;
  endtask

  task automatic t_reset_state;
    rd_chk("R3", 8'hE8, 8'hFF, 3'b000, bank_clash);
    rd_chk("R10", 8'h80, 8'h5A, 3'b000, bank_clash);
  endtask

  task automatic t_single_banks;
    wr_byte(8'hE8, 8'h00, 1'b0);
    rd_chk("R5", 8'h05, 8'h00, 3'b000, 1'b0);
    wr_byte(8'hE8, 8'h10, 1'b0);
    rd_chk("R1", 8'h05, 8'h44, 3'b100, 1'b0);
    wr_byte(8'hE8, 8'h01, 1'b0);
    rd_chk("R1", 8'h3F, 8'h11, 3'b001, 1'b0);
    wr_byte(8'hE8, 8'h02, 1'b0);
    rd_chk("R4", 8'h00, 8'h22, 3'b010, 1'b0);
    @(negedge clk);
    cpu_addr = 8'h2A; cpu_wr = 1'b1; cpu_wdata = 8'h99;
    #1;
    chk("R4", "we", int'(bank_we), 1);
    chk("R4", "cs", int'(bank_cs), 3'b010);
    chk("R4", "offset", int'(bank_offset), 8'h2A);
    cpu_wr = 1'b0;
    rd_chk("R11", 8'h00, 8'h22, 3'b010, 1'b0);
    rd_chk("R10", 8'h40, 8'h5A, 3'b000, 1'b0);
  endtask

  task automatic t_reserved_bits;
    wr_byte(8'hE8, 8'hEC, 1'b0);
    rd_chk("R2", 8'h10, 8'h00, 3'b000, 1'b0);
  endtask

  task automatic t_clash_and_hold;
    wr_byte(8'hE8, 8'h13, 1'b0);
    rd_chk("R9", 8'h07, 8'h77, 3'b111, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    rd_chk("R6", 8'h07, 8'h77, 3'b111, 1'b1);
    wr_byte(8'hE8, 8'h00, 1'b1);
    rd_chk("R7", 8'h01, 8'h77, 3'b111, 1'b1);
    wr_byte(8'hE9, 8'h00, 1'b0);
    rd_chk("R11", 8'h01, 8'h77, 3'b111, 1'b1);
    wr_byte(8'hE8, 8'h00, 1'b0);
    rd_chk("R5", 8'h01, 8'h00, 3'b000, 1'b0);
  endtask

  task automatic t_par_write;
    ee_par_wr_mode = 1'b1;
    wr_byte(8'hE8, 8'h13, 1'b0);
    rd_chk("R8", 8'h02, 8'h44, 3'b100, 1'b0);
    ee_par_wr_mode = 1'b0;
    wr_byte(8'hE8, 8'h01, 1'b0);
    ee_par_wr_mode = 1'b1;
    wr_byte(8'hE8, 8'h12, 1'b0);
    rd_chk("R8", 8'h02, 8'h55, 3'b101, 1'b1);
    ee_par_wr_mode = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_addr = 8'h80; cpu_wdata = 8'h00;
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_bitop = 1'b0; ee_par_wr_mode = 1'b0;
    map_rdata = 8'h5A; bank_rdata = {8'h44, 8'h22, 8'h11};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_single_banks();
    t_reserved_bits();
    t_clash_and_hold();
    t_par_write();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule